// File: doc/BRIEF.md
# Small-Page NAND Command Sequencer

This block turns one host request into the command and address cycles of a small-page NAND flash device. A request carries an opcode, an optional column, an optional page address and valid/ready handshake signals. The sequencer raises the command or address latch line for each byte and shapes the write-enable pulse. It drops the latch lines when the address phase ends, then waits on the device's ready/busy line as far as the opcode needs. When the sequence ends it returns a one-cycle done pulse to the host.

Two behaviours set it apart from a plain byte pusher. A sequential-data-input request gets a region-pointer command in front of it. That pointer is chosen from the column, and the column is rebased to match. Page reads keep chip enable driven low from the first page-address byte until the device reports ready. If the device stays busy, a microsecond-based timeout ends the hold. All other commands let chip enable go high between bus cycles. Bus timing comes from parameters counted in clock cycles, and the ready/busy input is synchronized inside the block.

Top module: `nand_cmd_seq`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle, and a request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. All request fields, `cfg_x16_i` and `cfg_large_i` are captured at acceptance. A valid request presented while busy is ignored and does not change the sequence in progress. Out of reset the block is idle: ready high, chip enable and write enable high, both latch lines low, done low.
- R2: Opcode 0x80 (sequential input) is preceded by a pointer command. If the column is at least PAGE_SIZE (512), the pointer is 0x50 and the column loses PAGE_SIZE. If the column is below 256, the pointer is 0x00. Otherwise the pointer is 0x01 and the column loses 256. Other opcodes send their column unchanged.
- R3: Command bytes go out with CLE high and ALE low. Address bytes go out with ALE high and CLE low. The two lines are never high together, and both are low when no byte is on the bus.
- R4: The column byte is sent only when `req_col_vld_i` is set, and page bytes are sent only when `req_page_vld_i` is set. With neither set, ALE never rises for that request.
- R5: With `cfg_x16_i` set, the column (after any R2 rebasing) is shifted right by one, and the low 8 bits are sent on `nand_dq_o[7:0]`.
- R6: Page bytes go out in this order: page[7:0], then page[15:8]. A third byte {4'b0, page[19:16]} follows only when `cfg_large_i` is set (device larger than 32 MiB).
- R7: For opcodes 0x00, 0x01 and 0x50 with a page address, chip enable stays low from the first page byte until synchronized ready/busy is high. If ready does not arrive within TIMEOUT_US microsecond ticks, the hold is released and `timeout_o` is raised with done.
- R8: After the last byte, ready/busy is not sampled for TWB_CYC cycles.
- R9: Opcodes 0x10, 0x60, 0xD0, 0x80 and 0x70 complete right after their bytes (and settle delay), without waiting on ready/busy.
- R10: Opcode 0xFF, any opcode not listed in R7 or R9, and a read sent without a page address all wait for ready/busy with no timeout.
- R11: When an address phase ends, SETTLE_CYC cycles pass with ALE low before anything follows.
- R12: `done_o` is a single-cycle pulse in the cycle after the sequence ends, and the block is idle in that cycle. `timeout_o` is high only together with `done_o`.
- R13: Every byte holds write enable low for WE_LO_CYC cycles and then high for WE_HI_CYC cycles, with the byte latched on the rising edge. Chip enable is low throughout every byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_x16_i | input | 1 | Device bus is 16 bits wide |
| cfg_large_i | input | 1 | Device capacity above 32 MiB |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_opcode_i | input | 8 | Command opcode |
| req_col_vld_i | input | 1 | Column present |
| req_col_i | input | COL_W | Column byte address |
| req_page_vld_i | input | 1 | Page address present |
| req_page_i | input | PAGE_W | Page address |
| done_o | output | 1 | Sequence finished (one-cycle pulse) |
| timeout_o | output | 1 | Read busy wait expired |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_we_no | output | 1 | Write enable, active low |
| nand_dq_o | output | DQ_W | Data bus, byte on bits 7:0 |
| nand_rb_i | input | 1 | Device ready (high) / busy (low) |

## Verification
Every bus byte is recorded at the rising edge of write enable, so a wrong pointer choice, column rebase, shift or page byte count shows up as a wrong byte or count within that request. A fault in the wait logic shows up as a wrong time from acceptance to done, a missing or extra timeout flag, or chip enable held high (or low) during the busy window. Each of these is visible by the done pulse of the request that caused it. Stray acceptance while busy would corrupt that request's byte list.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [7:0] OP_READ0   = 8'h00;
  localparam logic [7:0] OP_READ1   = 8'h01;
  localparam logic [7:0] OP_READOOB = 8'h50;
  localparam logic [7:0] OP_SEQIN   = 8'h80;
  localparam logic [7:0] OP_PROG    = 8'h10;
  localparam logic [7:0] OP_ERASE1  = 8'h60;
  localparam logic [7:0] OP_ERASE2  = 8'hD0;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PTR,
    ST_CMD,
    ST_COL,
    ST_PG0,
    ST_PG1,
    ST_PG2,
    ST_SETTLE,
    ST_TWB,
    ST_WAIT
  } seq_state_e;

  function automatic logic op_is_read(input logic [7:0] op);
    return (op == OP_READ0) || (op == OP_READ1) || (op == OP_READOOB);
  endfunction

  function automatic logic op_no_wait(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_ERASE1) || (op == OP_ERASE2) ||
           (op == OP_SEQIN) || (op == OP_STATUS);
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  output logic rb_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= rb_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], rb_i};
      end
    end
  endgenerate

  assign rb_o = sh_q[STAGES-1];
endmodule

// File: rtl/nand_us_tick.sv
module nand_us_tick #(
  parameter int DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = !clr_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nand_we_strobe.sv
module nand_we_strobe #(
  parameter int WE_LO_CYC = 3,
  parameter int WE_HI_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic we_no,
  output logic last_o
);
  localparam int TOT = WE_LO_CYC + WE_HI_CYC;
  localparam int CW  = (TOT > 1) ? $clog2(TOT) : 1;

  logic [CW-1:0] cnt_q;

  assign last_o = active_i && (cnt_q == CW'(TOT - 1));
  assign we_no  = !(active_i && (cnt_q < CW'(WE_LO_CYC)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!active_i || last_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_SIZE  = 512,
  parameter int COL_W      = 10,
  parameter int PAGE_W     = 20,
  parameter int DQ_W       = 16,
  parameter int WE_LO_CYC  = 3,
  parameter int WE_HI_CYC  = 2,
  parameter int TWB_CYC    = 25,
  parameter int SETTLE_CYC = 250,
  parameter int TICK_DIV   = 250,
  parameter int TIMEOUT_US = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_x16_i,
  input  logic              cfg_large_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        req_opcode_i,
  input  logic              req_col_vld_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_page_vld_i,
  input  logic [PAGE_W-1:0] req_page_i,
  output logic              done_o,
  output logic              timeout_o,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_ce_no,
  output logic              nand_we_no,
  output logic [DQ_W-1:0]   nand_dq_o,
  input  logic              nand_rb_i
);
  localparam int DLY_MAX = (SETTLE_CYC > TWB_CYC) ? SETTLE_CYC : TWB_CYC;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int TMO_W   = $clog2(TIMEOUT_US + 1);
  localparam int PG_EXT  = 24;

  seq_state_e        state_q;
  logic [7:0]        op_q, ptr_q, col_q;
  logic [PAGE_W-1:0] pg_q;
  logic              col_vld_q, pg_vld_q, large_q;
  logic              force_q, done_q, tmo_q;
  logic [DLY_W-1:0]  dly_q;
  logic [TMO_W-1:0]  us_q;

  logic              rb_s, tick, we_last, byte_act, in_wait, tmo_hit;
  logic [7:0]        ptr_d, bus_byte;
  logic [COL_W-1:0]  col_adj;
  logic [PG_EXT-1:0] pg_ext;

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rb_i  (nand_rb_i),
    .rb_o  (rb_s)
  );

  assign in_wait = (state_q == ST_WAIT);

  nand_us_tick #(.DIV(TICK_DIV)) u_us_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!in_wait),
    .tick_o(tick)
  );

  assign byte_act = (state_q == ST_PTR) || (state_q == ST_CMD) || (state_q == ST_COL) ||
                    (state_q == ST_PG0) || (state_q == ST_PG1) || (state_q == ST_PG2);

  nand_we_strobe #(.WE_LO_CYC(WE_LO_CYC), .WE_HI_CYC(WE_HI_CYC)) u_we_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(byte_act),
    .we_no   (nand_we_no),
    .last_o  (we_last)
  );

  // pointer selection and column rebasing, evaluated at acceptance
  always_comb begin
    ptr_d   = OP_READ0;
    col_adj = req_col_i;
    if (req_opcode_i == OP_SEQIN) begin
      if (req_col_i >= COL_W'(PAGE_SIZE)) begin
        ptr_d   = OP_READOOB;
        col_adj = req_col_i - COL_W'(PAGE_SIZE);
      end else if (req_col_i >= COL_W'(256)) begin
        ptr_d   = OP_READ1;
        col_adj = req_col_i - COL_W'(256);
      end
    end
    if (cfg_x16_i) col_adj = col_adj >> 1;
  end

  assign tmo_hit = tick && (us_q == TMO_W'(TIMEOUT_US - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      us_q <= '0;
    else if (!in_wait) us_q <= '0;
    else if (tick)    us_q <= us_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      ptr_q     <= '0;
      col_q     <= '0;
      pg_q      <= '0;
      col_vld_q <= 1'b0;
      pg_vld_q  <= 1'b0;
      large_q   <= 1'b0;
      force_q   <= 1'b0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      dly_q     <= '0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_q      <= req_opcode_i;
          ptr_q     <= ptr_d;
          col_q     <= col_adj[7:0];
          pg_q      <= req_page_i;
          col_vld_q <= req_col_vld_i;
          pg_vld_q  <= req_page_vld_i;
          large_q   <= cfg_large_i;
          state_q   <= (req_opcode_i == OP_SEQIN) ? ST_PTR : ST_CMD;
        end
        ST_PTR: if (we_last) state_q <= ST_CMD;
        ST_CMD: if (we_last) begin
          if (col_vld_q) begin
            state_q <= ST_COL;
          end else if (pg_vld_q) begin
            state_q <= ST_PG0;
            force_q <= op_is_read(op_q);
          end else if (op_no_wait(op_q)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_TWB;
            dly_q   <= DLY_W'(TWB_CYC - 1);
          end
        end
        ST_COL: if (we_last) begin
          if (pg_vld_q) begin
            state_q <= ST_PG0;
            force_q <= op_is_read(op_q);
          end else begin
            state_q <= ST_SETTLE;
            dly_q   <= DLY_W'(SETTLE_CYC - 1);
          end
        end
        ST_PG0: if (we_last) state_q <= ST_PG1;
        ST_PG1: if (we_last) begin
          if (large_q) begin
            state_q <= ST_PG2;
          end else begin
            state_q <= ST_SETTLE;
            dly_q   <= DLY_W'(SETTLE_CYC - 1);
          end
        end
        ST_PG2: if (we_last) begin
          state_q <= ST_SETTLE;
          dly_q   <= DLY_W'(SETTLE_CYC - 1);
        end
        ST_SETTLE: begin
          if (dly_q == '0) begin
            if (op_no_wait(op_q)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              force_q <= 1'b0;
            end else begin
              state_q <= ST_TWB;
              dly_q   <= DLY_W'(TWB_CYC - 1);
            end
          end else begin
            dly_q <= dly_q - 1'b1;
          end
        end
        ST_TWB: begin
          if (dly_q == '0) state_q <= ST_WAIT;
          else             dly_q   <= dly_q - 1'b1;
        end
        ST_WAIT: begin
          if (rb_s) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            force_q <= 1'b0;
          end else if (force_q && tmo_hit) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b1;
            force_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pg_ext = PG_EXT'(pg_q);

  always_comb begin
    unique case (state_q)
      ST_PTR:  bus_byte = ptr_q;
      ST_CMD:  bus_byte = op_q;
      ST_COL:  bus_byte = col_q;
      ST_PG0:  bus_byte = pg_ext[7:0];
      ST_PG1:  bus_byte = pg_ext[15:8];
      ST_PG2:  bus_byte = {4'b0000, pg_ext[19:16]};
      default: bus_byte = 8'h00;
    endcase
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;
  assign nand_cle_o  = (state_q == ST_PTR) || (state_q == ST_CMD);
  assign nand_ale_o  = (state_q == ST_COL) || (state_q == ST_PG0) ||
                       (state_q == ST_PG1) || (state_q == ST_PG2);
  assign nand_ce_no  = !(byte_act || force_q);
  assign nand_dq_o   = DQ_W'(bus_byte);

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int WE_LO_CYC  = 3,
  parameter int SETTLE_CYC = 250
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic done_o,
  input logic timeout_o,
  input logic nand_cle_o,
  input logic nand_ale_o,
  input logic nand_ce_no,
  input logic nand_we_no
);
  logic        armed_q, prev_we_q, prev_ale_q, pend_q;
  logic [15:0] lo_cnt_q, gap_q;
  logic        we_rose, we_fell, ale_fell;

  assign we_rose  = armed_q && !prev_we_q && nand_we_no;
  assign we_fell  = armed_q && prev_we_q && !nand_we_no;
  assign ale_fell = armed_q && prev_ale_q && !nand_ale_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      prev_we_q  <= 1'b1;
      prev_ale_q <= 1'b0;
      pend_q     <= 1'b0;
      lo_cnt_q   <= '0;
      gap_q      <= '0;
    end else begin
      armed_q    <= 1'b1;
      prev_we_q  <= nand_we_no;
      prev_ale_q <= nand_ale_o;
      lo_cnt_q   <= nand_we_no ? 16'd0 : lo_cnt_q + 16'd1;
      if (ale_fell)            gap_q <= '0;
      else if (gap_q != '1)    gap_q <= gap_q + 16'd1;
      if (ale_fell)            pend_q <= 1'b1;
      else if (we_fell)        pend_q <= 1'b0;
    end
  end

  assert_cle_ale_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (nand_we_no && !nand_cle_o && !nand_ale_o));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  assert_tmo_with_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);

  assert_we_ce_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> !nand_ce_no);

  assert_we_width_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_rose |-> (lo_cnt_q == 16'(WE_LO_CYC)));

  assert_settle_gap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && we_fell) |-> (gap_q >= 16'(SETTLE_CYC)));

endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(
  .WE_LO_CYC (WE_LO_CYC),
  .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o),
  .nand_cle_o (nand_cle_o),
  .nand_ale_o (nand_ale_o),
  .nand_ce_no (nand_ce_no),
  .nand_we_no (nand_we_no)
);

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
  localparam int COL_W = 10, PAGE_W = 20, DQ_W = 16;
  localparam int WE_LO = 3, WE_HI = 2, TWB = 25, SETTLE = 250, DIV = 250, TMO_US = 30;
  localparam int HUGE = 30000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_x16 = 1'b0, cfg_large = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_op = '0;
  logic req_col_vld = 1'b0, req_pg_vld = 1'b0;
  logic [COL_W-1:0] req_col = '0;
  logic [PAGE_W-1:0] req_pg = '0;
  logic done, tmo, cle, ale, ce_n, we_n, rb = 1'b1;
  logic [DQ_W-1:0] dq;

  always #2 clk = ~clk;

  nand_cmd_seq u_nand_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_x16_i(cfg_x16), .cfg_large_i(cfg_large),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_opcode_i(req_op),
    .req_col_vld_i(req_col_vld), .req_col_i(req_col), .req_page_vld_i(req_pg_vld),
    .req_page_i(req_pg), .done_o(done), .timeout_o(tmo), .nand_cle_o(cle),
    .nand_ale_o(ale), .nand_ce_no(ce_n), .nand_we_no(we_n), .nand_dq_o(dq),
    .nand_rb_i(rb)
  );

  int checks = 0, errors = 0;
  int cyc = 0, rb_rise = 0;
  int got_n = 0, exp_n = 0, acc_cyc = 0, done_cyc = 0, ce_cnt = 0, ce_at_done = 0, lo_run = 0;
  bit done_seen = 0, done_tmo = 0, prev_we = 1;
  logic [9:0] got_q [16];
  logic [9:0] exp_q [8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) rb <= (cyc >= rb_rise);

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_valid && req_ready) begin got_n = 0; done_seen = 0; acc_cyc = cyc; end
      if (done) begin done_seen = 1; done_cyc = cyc; done_tmo = tmo; ce_at_done = ce_cnt; end
      if (we_n && !prev_we) begin
        if (got_n < 16) got_q[got_n] = {cle, ale, dq[7:0]};
        got_n++;
        chk(lo_run == WE_LO, "R13 we low width", lo_run, WE_LO);
        ce_cnt = 0;
        lo_run = 0;
      end
      if (!we_n) lo_run++;
      if (!ce_n) ce_cnt++;
      prev_we = we_n;
    end
  end

  function automatic bit is_rd(input logic [7:0] op);
    return op == 8'h00 || op == 8'h01 || op == 8'h50;
  endfunction
  function automatic bit no_wait(input logic [7:0] op);
    return op == 8'h10 || op == 8'h60 || op == 8'hD0 || op == 8'h80 || op == 8'h70;
  endfunction

  task automatic build_exp(input logic [7:0] op, input bit colv, input int col,
                           input bit pgv, input int pg, input bit x16, input bit lg);
    int c;
    c = col;
    exp_n = 0;
    if (op == 8'h80) begin
      if (c >= 512)      begin exp_q[exp_n] = {2'b10, 8'h50}; c = c - 512; end
      else if (c < 256)  begin exp_q[exp_n] = {2'b10, 8'h00}; end
      else               begin exp_q[exp_n] = {2'b10, 8'h01}; c = c - 256; end
      exp_n++;
    end
    exp_q[exp_n] = {2'b10, op}; exp_n++;
    if (x16) c = c >> 1;
    if (colv) begin exp_q[exp_n] = {2'b01, 8'(c & 255)}; exp_n++; end
    if (pgv) begin
      exp_q[exp_n] = {2'b01, 8'(pg & 255)}; exp_n++;
      exp_q[exp_n] = {2'b01, 8'((pg >> 8) & 255)}; exp_n++;
      if (lg) begin exp_q[exp_n] = {2'b01, 8'((pg >> 16) & 15)}; exp_n++; end
    end
  endtask

  int lat;

  task automatic run_case(input logic [7:0] op, input bit colv, input int col,
                          input bit pgv, input int pg, input bit x16, input bit lg,
                          input int delay, input bit noise, input string tag);
    int n;
    bit forced, exp_tmo;
    while (!req_ready) begin @(posedge clk); #1; end
    build_exp(op, colv, col, pgv, pg, x16, lg);
    cfg_x16 = x16; cfg_large = lg;
    req_op = op; req_col_vld = colv; req_col = COL_W'(col);
    req_pg_vld = pgv; req_pg = PAGE_W'(pg);
    req_valid = 1'b1;
    rb_rise = cyc + delay;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready low while busy", int'(req_ready), 0);
    if (noise) begin
      req_op = 8'h70; req_col_vld = 1'b0; req_pg_vld = 1'b0; req_valid = 1'b1;
      repeat (3) begin @(posedge clk); #1; end
      req_valid = 1'b0;
    end
    n = 0;
    while (!done_seen && n < 40000) begin @(posedge clk); #1; n++; end
    chk(done_seen, "R12 done seen", int'(done_seen), 1);
    lat = done_cyc - acc_cyc;
    chk(got_n == exp_n, {tag, " byte count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got_q[i] == exp_q[i], {tag, " byte"}, int'(got_q[i]), int'(exp_q[i]));
    forced  = is_rd(op) && pgv;
    exp_tmo = forced && (delay >= 10000);
    chk(done_tmo == exp_tmo, "R7 timeout flag", int'(done_tmo), int'(exp_tmo));
    if (forced) chk(ce_at_done > WE_HI + SETTLE, "R7 ce held", ce_at_done, WE_HI + SETTLE + 1);
    else        chk(ce_at_done == WE_HI, "R13 ce released", ce_at_done, WE_HI);
    if (no_wait(op)) chk(lat < 400, "R9 no busy wait", lat, 400);
    @(posedge clk); #1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 1'b1 && ce_n && we_n && !cle && !ale && !done, "R1 reset state",
        int'({req_ready, ce_n, we_n, cle, ale, done}), 'b111000);
    rst_n = 1'b1;
    @(posedge clk); #1;

    run_case(8'h80, 1, 10,  1, 'h1234, 0, 0, 0, 0, "R2 seqin low col");
    run_case(8'h80, 1, 300, 1, 'h1234, 0, 0, 0, 1, "R2 seqin mid col R1 noise");
    run_case(8'h80, 1, 520, 1, 'h0055, 0, 0, 0, 0, "R2 seqin oob col");
    run_case(8'h80, 1, 300, 1, 'hABCDE, 1, 1, 0, 0, "R5 R6 x16 large");
    run_case(8'h00, 1, 200, 1, 'hABCDE, 1, 0, 100, 0, "R5 R6 x16 small read");
    run_case(8'h60, 0, 0,   1, 'h0F0F0, 0, 1, HUGE, 0, "R4 erase page only");
    run_case(8'h70, 0, 0,   0, 0, 0, 0, HUGE, 0, "R4 R9 status no addr");
    chk(got_n == 1, "R4 no ale phase", got_n, 1);

    run_case(8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, "R8 reset ready");
    chk(lat >= WE_LO + WE_HI + TWB, "R8 twb min", lat, WE_LO + WE_HI + TWB);
    run_case(8'hFF, 0, 0, 0, 0, 0, 0, 1500, 0, "R10 reset busy");
    chk(lat >= 1500 && lat <= 1510, "R10 reset waits ready", lat, 1503);
    run_case(8'h01, 1, 7, 0, 0, 0, 0, 0, 0, "R11 read col only");
    chk(lat >= 2 * (WE_LO + WE_HI) + SETTLE + TWB, "R11 settle", lat, 2 * (WE_LO + WE_HI) + SETTLE + TWB);
    run_case(8'h00, 0, 0, 0, 0, 0, 0, HUGE / 2, 0, "R10 read no page");
    chk(lat >= HUGE / 2 && !done_tmo, "R10 no timeout without page", lat, HUGE / 2);
    run_case(8'h00, 1, 3, 1, 'h321, 0, 0, HUGE, 0, "R7 read timeout");
    chk(lat >= TMO_US * DIV && lat < TMO_US * DIV + 400, "R7 timeout window", lat, TMO_US * DIV);
    run_case(8'h50, 1, 4, 1, 'h777, 0, 1, 800, 0, "R7 oob read ready");
    chk(lat >= 800 && lat <= 810, "R7 released on ready", lat, 803);

    for (int k = 0; k < 40; k++) begin
      logic [7:0] ops [9];
      logic [7:0] op;
      ops = '{8'h00, 8'h01, 8'h50, 8'h80, 8'h10, 8'h60, 8'hD0, 8'h70, 8'hFF};
      op = ops[$urandom_range(8, 0)];
      run_case(op, 1'($urandom_range(1, 0)), int'($urandom_range(527, 0)),
               1'($urandom_range(1, 0)), int'($urandom_range(20'hFFFFF, 0)),
               1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
               int'($urandom_range(600, 0)), 0, "R2 R3 R4 R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R12 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule